// File: doc/BRIEF.md
# Per-Thread Instruction Serialization Gate

This block sits at the operand-access stage of an in-order, multithreaded pipeline. Each cycle it looks at the instruction presented for one thread and decides whether that instruction may proceed or must stall. It does this using a small amount of per-thread state and the instruction's classification flags.

For each thread the block keeps two pieces of state. The first is a deferred-serialization marker, together with the sequence number that armed it. The second is a barrier bit, together with the sequence number of the non-speculative instruction that raised it.

- An instruction that must drain the thread before it runs waits until it is the oldest instruction of its thread. This covers instructions marked serialize-before, instructions that touch a control register, and instructions made serializing by an armed marker.
- An instruction that orders later work arms the marker for its thread. This covers serialize-after instructions and store-conditionals.
- While the barrier bit is up, every younger instruction of the thread is held.
- An instruction that already carries a fault passes through with a fault-pass indication, without touching the barrier.
- A graduation strobe carrying a thread number lowers that thread's barrier bit.

The decision outputs are combinational from the current state and the presented instruction. State changes only on a clock edge where a valid instruction is presented, or where a graduation strobe is present.

Top module: `serial_gate`

## Requirements
- R1: After synchronous reset every thread's marker and barrier are inactive and both recorded sequence numbers are zero, so an unflagged instruction of any thread proceeds.
- R2: A valid instruction that needs the thread drained (serialize-before, control-register access, or promoted by R4) raises stall, not proceed, in the same cycle when in_oldest is 0; with in_oldest 1 it passes this gate.
- R3: A serialize-after or store-conditional instruction that passes the R2 gate arms its thread's marker and records its own sequence number, even if R6 then stalls it.
- R4: With the marker armed, an instruction whose sequence number is strictly greater than the recorded one counts as serialize-before. When such an instruction passes the R2 gate the marker is disarmed, unless that same instruction re-arms it per R3. Equal or smaller sequence numbers are not promoted.
- R5: A faulted instruction that passes the R2 gate proceeds with fault_pass 1 in the same cycle, ignores the barrier, and does not raise it; fault_pass is 0 in every other case.
- R6: While a thread's barrier is up, a non-faulted instruction of that thread with a sequence number strictly greater than the recorded one stalls; equal or smaller numbers are not held by the barrier.
- R7: A non-speculative, non-faulted instruction that proceeds raises its thread's barrier and records its sequence number.
- R8: grad_valid with grad_tid lowers that thread's barrier at the next edge; when a non-speculative instruction of the same thread raises the barrier in the same cycle, the barrier ends up raised.
- R9: State of each thread changes only through instructions or graduations of that thread.
- R10: With in_valid 0, stall, proceed and fault_pass are all 0 and no marker or recorded number changes.
- R11: stall and proceed are never both 1, and when in_valid is 1 exactly one of them is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_tid | input | TID_W | Thread of the presented instruction |
| in_seq | input | SEQ_W | Sequence number of the presented instruction |
| in_ser_before | input | 1 | Instruction must wait for an empty thread |
| in_ser_after | input | 1 | Instruction serializes the ones after it |
| in_store_cond | input | 1 | Instruction is a store-conditional |
| in_ctrl_reg | input | 1 | Instruction accesses a control register |
| in_nonspec | input | 1 | Instruction is non-speculative |
| in_faulted | input | 1 | Instruction already carries a fault |
| in_oldest | input | 1 | Instruction is the oldest in flight in its thread |
| grad_valid | input | 1 | A non-speculative instruction graduated |
| grad_tid | input | TID_W | Thread of the graduating instruction |
| stall | output | 1 | Presented instruction must wait |
| proceed | output | 1 | Presented instruction may move on |
| fault_pass | output | 1 | Presented instruction proceeds only to carry its fault |

## Verification
The bench concentrates on sequence-number comparisons at equality, since an off-by-one compare would either hold the barrier instruction itself or fail to promote the instruction right after a serialize-after. It exercises a faulted instruction that is younger than an active barrier; a design that tested the barrier first would stall it instead of passing the fault. It drives a graduation and a new barrier in the same cycle, where a wrong priority leaves the thread unguarded. It also crosses threads to expose state that leaks from one thread into another, and it runs a long pseudo-random mix over small sequence numbers against an arithmetic model.

// File: rtl/serial_gate_pkg.sv
package serial_gate_pkg;

  typedef struct packed {
    logic ser_before;
    logic ser_after;
    logic store_cond;
    logic ctrl_reg;
    logic nonspec;
    logic faulted;
  } insn_class_t;

endpackage

// File: rtl/serial_gate_thread.sv
module serial_gate_thread #(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEQ_W-1:0] seq,
  input  logic             arm_mark,
  input  logic             disarm_mark,
  input  logic             raise_bar,
  input  logic             lower_bar,
  output logic             mark,
  output logic [SEQ_W-1:0] mark_seq,
  output logic             bar,
  output logic [SEQ_W-1:0] bar_seq
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mark     <= 1'b0;
      mark_seq <= '0;
    end else if (arm_mark) begin
      mark     <= 1'b1;
      mark_seq <= seq;
    end else if (disarm_mark) begin
      mark     <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bar     <= 1'b0;
      bar_seq <= '0;
    end else if (raise_bar) begin
      bar     <= 1'b1;
      bar_seq <= seq;
    end else if (lower_bar) begin
      bar     <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_gate_decide.sv
module serial_gate_decide
  import serial_gate_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             valid,
  input  insn_class_t      cls,
  input  logic             oldest,
  input  logic [SEQ_W-1:0] seq,
  input  logic             mark,
  input  logic [SEQ_W-1:0] mark_seq,
  input  logic             bar,
  input  logic [SEQ_W-1:0] bar_seq,
  output logic             stall,
  output logic             proceed,
  output logic             fault_pass,
  output logic             arm_mark,
  output logic             disarm_mark,
  output logic             raise_bar
);

  logic promoted;
  logic needs_drain;
  logic gate_ok;
  logic held_by_bar;

  always_comb begin
    promoted    = mark && (seq > mark_seq);
    needs_drain = cls.ser_before || cls.ctrl_reg || promoted;
    gate_ok     = !needs_drain || oldest;
    held_by_bar = bar && (seq > bar_seq) && !cls.faulted;

    stall       = valid && (!gate_ok || held_by_bar);
    proceed     = valid && !stall;
    fault_pass  = proceed && cls.faulted;
    arm_mark    = valid && gate_ok && (cls.ser_after || cls.store_cond);
    disarm_mark = valid && gate_ok && promoted;
    raise_bar   = proceed && cls.nonspec && !cls.faulted;
  end

endmodule

// File: rtl/serial_gate.sv
module serial_gate
  import serial_gate_pkg::*;
#(
  parameter int THREADS = 2,
  parameter int SEQ_W   = 16,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [TID_W-1:0] in_tid,
  input  logic [SEQ_W-1:0] in_seq,
  input  logic             in_ser_before,
  input  logic             in_ser_after,
  input  logic             in_store_cond,
  input  logic             in_ctrl_reg,
  input  logic             in_nonspec,
  input  logic             in_faulted,
  input  logic             in_oldest,
  input  logic             grad_valid,
  input  logic [TID_W-1:0] grad_tid,
  output logic             stall,
  output logic             proceed,
  output logic             fault_pass
);

  insn_class_t cls;
  logic [THREADS-1:0] mark_v;
  logic [THREADS-1:0] bar_v;
  logic [SEQ_W-1:0]   mark_seq_v [THREADS];
  logic [SEQ_W-1:0]   bar_seq_v  [THREADS];

  logic             sel_mark;
  logic             sel_bar;
  logic [SEQ_W-1:0] sel_mark_seq;
  logic [SEQ_W-1:0] sel_bar_seq;
  logic             arm_mark;
  logic             disarm_mark;
  logic             raise_bar;

  always_comb begin
    cls.ser_before = in_ser_before;
    cls.ser_after  = in_ser_after;
    cls.store_cond = in_store_cond;
    cls.ctrl_reg   = in_ctrl_reg;
    cls.nonspec    = in_nonspec;
    cls.faulted    = in_faulted;
  end

  always_comb begin
    sel_mark     = 1'b0;
    sel_bar      = 1'b0;
    sel_mark_seq = '0;
    sel_bar_seq  = '0;
    for (int i = 0; i < THREADS; i++) begin
      if (in_tid == TID_W'(i)) begin
        sel_mark     = mark_v[i];
        sel_bar      = bar_v[i];
        sel_mark_seq = mark_seq_v[i];
        sel_bar_seq  = bar_seq_v[i];
      end
    end
  end

  serial_gate_decide #(.SEQ_W(SEQ_W)) u_decide (
    .valid       (in_valid),
    .cls         (cls),
    .oldest      (in_oldest),
    .seq         (in_seq),
    .mark        (sel_mark),
    .mark_seq    (sel_mark_seq),
    .bar         (sel_bar),
    .bar_seq     (sel_bar_seq),
    .stall       (stall),
    .proceed     (proceed),
    .fault_pass  (fault_pass),
    .arm_mark    (arm_mark),
    .disarm_mark (disarm_mark),
    .raise_bar   (raise_bar)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    logic mine;
    assign mine = (in_tid == TID_W'(t));
    serial_gate_thread #(.SEQ_W(SEQ_W)) u_thr (
      .clk         (clk),
      .rst         (rst),
      .seq         (in_seq),
      .arm_mark    (arm_mark && mine),
      .disarm_mark (disarm_mark && mine),
      .raise_bar   (raise_bar && mine),
      .lower_bar   (grad_valid && (grad_tid == TID_W'(t))),
      .mark        (mark_v[t]),
      .mark_seq    (mark_seq_v[t]),
      .bar         (bar_v[t]),
      .bar_seq     (bar_seq_v[t])
    );
  end

endmodule

// File: rtl/serial_gate_chk.sv
module serial_gate_chk #(
  parameter int THREADS = 2,
  parameter int TID_W   = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [TID_W-1:0]   in_tid,
  input logic               in_ser_before,
  input logic               in_ctrl_reg,
  input logic               in_nonspec,
  input logic               in_faulted,
  input logic               in_oldest,
  input logic               grad_valid,
  input logic [TID_W-1:0]   grad_tid,
  input logic               stall,
  input logic               proceed,
  input logic               fault_pass,
  input logic [THREADS-1:0] bar_v
);

  p_drain_wait_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && (in_ser_before || in_ctrl_reg) && !in_oldest |-> stall);

  p_fault_go_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_faulted && !in_ser_before && !in_ctrl_reg && in_oldest |-> proceed && fault_pass);

  p_fault_flag_r5: assert property (@(posedge clk) disable iff (rst)
    fault_pass |-> proceed && in_faulted);

  p_one_hot_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> $onehot({stall, proceed}));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> !stall && !proceed && !fault_pass);

  p_grad_lower_r8: assert property (@(posedge clk) disable iff (rst)
    grad_valid && grad_tid == '0 && !(in_valid && in_tid == '0 && proceed && in_nonspec && !in_faulted)
    |=> !bar_v[0]);

  p_bar_raise_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_tid == '0 && proceed && in_nonspec && !in_faulted |=> bar_v[0]);

endmodule

bind serial_gate serial_gate_chk #(.THREADS(THREADS), .TID_W(TID_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_tid        (in_tid),
  .in_ser_before (in_ser_before),
  .in_ctrl_reg   (in_ctrl_reg),
  .in_nonspec    (in_nonspec),
  .in_faulted    (in_faulted),
  .in_oldest     (in_oldest),
  .grad_valid    (grad_valid),
  .grad_tid      (grad_tid),
  .stall         (stall),
  .proceed       (proceed),
  .fault_pass    (fault_pass),
  .bar_v         (bar_v)
);

// File: tb/serial_gate_tb.sv
module serial_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int THREADS = 2;
  localparam int SEQ_W = 16;
  localparam int TID_W = 1;

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_tid = 0;
  logic [SEQ_W-1:0] in_seq = 0;
  logic sb = 0, sa = 0, sc = 0, cr = 0, ns = 0, ft = 0, old = 0;
  logic grad_valid = 0, grad_tid = 0;
  logic stall, proceed, fault_pass;

  int n_chk = 0, n_fail = 0;
  logic m_mark [THREADS]; logic [SEQ_W-1:0] m_mseq [THREADS];
  logic m_bar  [THREADS]; logic [SEQ_W-1:0] m_bseq [THREADS];
  logic [31:0] rs = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_gate #(.THREADS(THREADS), .SEQ_W(SEQ_W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tid(in_tid), .in_seq(in_seq),
    .in_ser_before(sb), .in_ser_after(sa), .in_store_cond(sc), .in_ctrl_reg(cr),
    .in_nonspec(ns), .in_faulted(ft), .in_oldest(old),
    .grad_valid(grad_valid), .grad_tid(grad_tid),
    .stall(stall), .proceed(proceed), .fault_pass(fault_pass));

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {stall,proceed,fault_pass} actual %b expected %b", req, act, exp);
    end
  endtask

  // Present one cycle: drive after negedge, check before posedge, update model.
  task automatic step(input string req, input logic v, input logic t, input int s,
                      input logic [6:0] f, input logic gv, input logic gt);
    logic prom, gate, held, e_st, e_pr, e_fp;
    @(negedge clk);
    in_valid = v; in_tid = t; in_seq = SEQ_W'(s);
    {sb, sa, sc, cr, ns, ft, old} = f;
    grad_valid = gv; grad_tid = gt;
    #1;
    prom = m_mark[t] && (in_seq > m_mseq[t]);
    gate = !(sb || cr || prom) || old;
    held = m_bar[t] && (in_seq > m_bseq[t]) && !ft;
    e_st = v && (!gate || held);
    e_pr = v && !e_st;
    e_fp = e_pr && ft;
    check(req, {stall, proceed, fault_pass}, {e_st, e_pr, e_fp});
    if (gv) m_bar[gt] = 1'b0;
    if (v && gate && prom) m_mark[t] = 1'b0;
    if (v && gate && (sa || sc)) begin m_mark[t] = 1'b1; m_mseq[t] = in_seq; end
    if (e_pr && ns && !ft) begin m_bar[t] = 1'b1; m_bseq[t] = in_seq; end
  endtask

  // flag order: sb sa sc cr ns ft old
  localparam logic [6:0] PLAIN = 7'b0000000, OLD = 7'b0000001;
  localparam logic [6:0] SB = 7'b1000000, CR = 7'b0001000, SA = 7'b0100000;
  localparam logic [6:0] SC = 7'b0010000, NS = 7'b0000100, FT = 7'b0000010;

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < THREADS; i++) begin
      m_mark[i] = 0; m_mseq[i] = 0; m_bar[i] = 0; m_bseq[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset: plain instructions proceed on both threads
    step("R1 t0", 1, 0, 5, PLAIN, 0, 0);
    step("R1 t1", 1, 1, 5, PLAIN, 0, 0);
    // R10 idle
    step("R10 idle", 0, 0, 9, SA | NS, 0, 0);
    step("R10 after idle", 1, 0, 10, PLAIN, 0, 0);
    // R2
    step("R2 sb young", 1, 0, 11, SB, 0, 0);
    step("R2 cr young", 1, 0, 11, CR, 0, 0);
    step("R2 sb oldest", 1, 0, 11, SB | OLD, 0, 0);
    // R3 / R4
    step("R3 sa arms", 1, 0, 20, SA, 0, 0);
    step("R4 equal seq", 1, 0, 20, PLAIN, 0, 0);
    step("R4 younger stalls", 1, 0, 21, PLAIN, 0, 0);
    step("R9 other thread", 1, 1, 21, PLAIN, 0, 0);
    step("R4 younger oldest", 1, 0, 21, OLD, 0, 0);
    step("R4 disarmed", 1, 0, 22, PLAIN, 0, 0);
    step("R3 sc arms", 1, 0, 30, SC, 0, 0);
    step("R4 sc promote", 1, 0, 31, PLAIN, 0, 0);
    step("R4 rearm", 1, 0, 31, SA | OLD, 0, 0);
    step("R4 still armed", 1, 0, 32, PLAIN, 0, 0);
    step("R4 clear", 1, 0, 32, OLD, 0, 0);
    // R7 / R6 / R5 / R8
    step("R7 raise", 1, 0, 40, NS, 0, 0);
    step("R6 equal", 1, 0, 40, PLAIN, 0, 0);
    step("R6 older", 1, 0, 39, PLAIN, 0, 0);
    step("R6 younger", 1, 0, 41, PLAIN, 0, 0);
    step("R5 fault past bar", 1, 0, 41, FT, 0, 0);
    step("R9 t1 free", 1, 1, 41, PLAIN, 0, 0);
    step("R8 grad other", 0, 0, 0, PLAIN, 1, 1);
    step("R8 still held", 1, 0, 41, PLAIN, 0, 0);
    step("R8 grad", 0, 0, 0, PLAIN, 1, 0);
    step("R8 released", 1, 0, 41, PLAIN, 0, 0);
    step("R8 set wins", 1, 0, 50, NS, 1, 0);
    step("R8 held after tie", 1, 0, 51, PLAIN, 0, 0);
    step("R5 fault no raise", 0, 0, 0, PLAIN, 1, 0);
    step("R5 fault ns", 1, 0, 60, FT | NS, 0, 0);
    step("R5 no bar", 1, 0, 61, PLAIN, 0, 0);
    step("R3 sa then bar", 1, 1, 70, NS, 0, 0);
    step("R3 arms while held", 1, 1, 71, SA, 0, 0);
    step("R8 grad t1", 0, 0, 0, PLAIN, 1, 1);
    step("R3 mark kept", 1, 1, 72, PLAIN, 0, 0);
    // R11 pseudo-random sweep with small sequence numbers
    for (int k = 0; k < 3000; k++) begin
      rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
      step("R11 sweep", rs[0] | rs[1], rs[2], int'(rs[6:4]),
           {rs[8] & rs[9], rs[10] & rs[11], rs[12] & rs[13], rs[14] & rs[15],
            rs[16] & rs[17], rs[18] & rs[19] & rs[20], rs[21]},
           rs[22] & rs[23], rs[24]);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule